// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block routes a group of interrupt input lines to processors through a request/acknowledge delivery port. Each input owns one routing entry holding a vector, a mask, a trigger mode, a polarity, a destination mode and a destination ID. Software sets the entries through a narrow register window. It first writes an internal register index at one bus offset. It then reads or writes the selected 32-bit register at a second offset.

Every input is first corrected for polarity. An edge-mode input latches a pending flag on a rising edge of the corrected signal. A level-mode input requests for as long as the corrected signal is high and it is not in service. A fixed-priority arbiter picks the lowest-numbered unmasked requester. A two-state machine then offers that entry's vector, destination ID and destination mode until the acknowledge arrives.

The delivery machine has two states. In `ST_IDLE` no request is offered. The transition idle-to-offer is taken on any arbiter win, and the winner's fields are captured on that edge. In `ST_OFFER` the request is held with frozen fields. The transition offer-to-idle is taken on `dlv_ack`. A level-mode entry whose offer is acknowledged enters service. It stays there until an end-of-interrupt pulse carries its vector.

Top module: `irq_router`

## Requirements
- R1: Bus offset 0x00 holds an 8-bit index register that reads back in bits 7:0. Bus offset 0x10 reads or writes the internal register chosen by that index. Other offsets read zero.
- R2: Internal index 0x00 holds a 4-bit ID in bits 27:24 that software can write. All other bits of that register read zero.
- R3: Internal index 0x01 is read-only. Bits 7:0 hold the version (0x20). Bits 23:16 hold the entry count minus one (23). Writes to it have no effect.
- R4: For input n, the low word is at index 0x10+2n and the high word is at index 0x10+2n+1. In the low word, bits 7:0 are the vector, bit 16 is the mask, bit 15 selects level mode, bit 13 selects active-low and bit 11 selects logical destination mode. The high word holds the destination in bits 31:24, and all its other bits read zero.
- R5: After reset, every low word reads 0x0001_0000 (masked, edge, active-high, vector 0), every high word reads zero, and no delivery is requested.
- R6: Indices 0x02 to 0x0F and those at or above 0x40 read zero, and writes to them have no effect.
- R7: In edge mode, a rising edge of the corrected input latches one delivery. That delivery carries the entry's vector, destination and mode, and the acknowledge consumes it.
- R8: With bit 13 set, a falling edge of the input line counts as the rising edge of the corrected input.
- R9: An acknowledged level-mode input sets low-word bit 14 and is not requested again until `eoi_valid` pulses with an `eoi_vector` equal to its vector. Any other vector leaves it in service.
- R10: When several unmasked inputs are pending, the lowest-numbered input is delivered first.
- R11: While `dlv_req` is high without `dlv_ack`, the request and its vector, destination and mode hold steady. The cycle after the acknowledge, `dlv_req` is low.
- R12: An edge event that occurs while its entry is masked stays latched. It is delivered once the mask is cleared.
- R13: Low-word bit 14 is read-only, and software writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the bus access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read enable; read data is combinational |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when bus_rd is low |
| irq_in | input | NUM_IN | Raw interrupt input lines |
| eoi_valid | input | 1 | End-of-interrupt pulse |
| eoi_vector | input | 8 | Vector being retired |
| dlv_req | output | 1 | Delivery request |
| dlv_vector | output | 8 | Vector of the offered interrupt |
| dlv_dest | output | 8 | Destination ID of the offered interrupt |
| dlv_logical | output | 1 | Destination mode of the offered interrupt |
| dlv_ack | input | 1 | Delivery acknowledge |

## Verification
A corrupted pending flag appears as a missing delivery or an extra delivery on `dlv_req`, within two cycles of the input event or of the unmask. A stuck in-service bit shows up in two ways. It can be read directly through low-word bit 14. It also keeps a level input silent after the matching end-of-interrupt, which is visible two cycles after the pulse. Register-file faults appear on the very next window read, and wrong arbitration shows in the vector of the first offer.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } dlv_state_e;

    localparam logic [7:0] ADDR_INDEX = 8'h00;
    localparam logic [7:0] ADDR_DATA  = 8'h10;
    localparam logic [7:0] IDX_ID     = 8'h00;
    localparam logic [7:0] IDX_VER    = 8'h01;
    localparam int         TBL_BASE   = 16;

    localparam int B_MASK    = 16;
    localparam int B_LEVEL   = 15;
    localparam int B_INSVC   = 14;
    localparam int B_ACTLOW  = 13;
    localparam int B_LOGICAL = 11;
endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_router_pkg::*;
#(
    parameter int         NUM_IN  = 24,
    parameter logic [7:0] VERSION = 8'h20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [7:0]             bus_addr,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic [NUM_IN-1:0]      insvc,
    output logic [NUM_IN-1:0]      cfg_mask,
    output logic [NUM_IN-1:0]      cfg_level,
    output logic [NUM_IN-1:0]      cfg_actlow,
    output logic [NUM_IN-1:0]      cfg_logical,
    output logic [NUM_IN-1:0][7:0] cfg_vec,
    output logic [NUM_IN-1:0][7:0] cfg_dest
);
    localparam logic [7:0] MAX_ENTRY = 8'(NUM_IN - 1);

    logic [7:0]  idx_q;
    logic [3:0]  id_q;
    logic        data_wr;
    logic [31:0] rd_val;

    assign data_wr = bus_wr && (bus_addr == ADDR_DATA);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q       <= '0;
            id_q        <= '0;
            cfg_mask    <= '1;
            cfg_level   <= '0;
            cfg_actlow  <= '0;
            cfg_logical <= '0;
            cfg_vec     <= '0;
            cfg_dest    <= '0;
        end else begin
            if (bus_wr && (bus_addr == ADDR_INDEX)) begin
                idx_q <= bus_wdata[7:0];
            end
            if (data_wr && (idx_q == IDX_ID)) begin
                id_q <= bus_wdata[27:24];
            end
            for (int i = 0; i < NUM_IN; i++) begin
                if (data_wr && (idx_q == 8'(TBL_BASE + 2*i))) begin
                    cfg_vec[i]     <= bus_wdata[7:0];
                    cfg_mask[i]    <= bus_wdata[B_MASK];
                    cfg_level[i]   <= bus_wdata[B_LEVEL];
                    cfg_actlow[i]  <= bus_wdata[B_ACTLOW];
                    cfg_logical[i] <= bus_wdata[B_LOGICAL];
                end
                if (data_wr && (idx_q == 8'(TBL_BASE + 2*i + 1))) begin
                    cfg_dest[i] <= bus_wdata[31:24];
                end
            end
        end
    end

    always_comb begin
        rd_val = '0;
        if (bus_addr == ADDR_INDEX) begin
            rd_val[7:0] = idx_q;
        end else if (bus_addr == ADDR_DATA) begin
            if (idx_q == IDX_ID) begin
                rd_val[27:24] = id_q;
            end else if (idx_q == IDX_VER) begin
                rd_val[7:0]   = VERSION;
                rd_val[23:16] = MAX_ENTRY;
            end else begin
                for (int i = 0; i < NUM_IN; i++) begin
                    if (idx_q == 8'(TBL_BASE + 2*i)) begin
                        rd_val[7:0]       = cfg_vec[i];
                        rd_val[B_MASK]    = cfg_mask[i];
                        rd_val[B_LEVEL]   = cfg_level[i];
                        rd_val[B_INSVC]   = insvc[i];
                        rd_val[B_ACTLOW]  = cfg_actlow[i];
                        rd_val[B_LOGICAL] = cfg_logical[i];
                    end
                    if (idx_q == 8'(TBL_BASE + 2*i + 1)) begin
                        rd_val[31:24] = cfg_dest[i];
                    end
                end
            end
        end
        bus_rdata = bus_rd ? rd_val : 32'h0;
    end
endmodule

// File: rtl/irq_detect.sv
module irq_detect #(
    parameter int NUM_IN = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_IN-1:0]      irq_in,
    input  logic [NUM_IN-1:0]      cfg_mask,
    input  logic [NUM_IN-1:0]      cfg_level,
    input  logic [NUM_IN-1:0]      cfg_actlow,
    input  logic [NUM_IN-1:0][7:0] cfg_vec,
    input  logic [NUM_IN-1:0]      ack_hot,
    input  logic                   eoi_valid,
    input  logic [7:0]             eoi_vector,
    output logic [NUM_IN-1:0]      req,
    output logic [NUM_IN-1:0]      insvc
);
    for (genvar g = 0; g < NUM_IN; g++) begin : g_line
        logic cond;
        logic prev_q;
        logic pend_q;
        logic svc_q;

        assign cond = irq_in[g] ^ cfg_actlow[g];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                pend_q <= 1'b0;
                svc_q  <= 1'b0;
            end else begin
                prev_q <= cond;
                pend_q <= (pend_q && !ack_hot[g])
                          || (!cfg_level[g] && cond && !prev_q);
                if (ack_hot[g] && cfg_level[g]) begin
                    svc_q <= 1'b1;
                end else if (eoi_valid && (eoi_vector == cfg_vec[g])) begin
                    svc_q <= 1'b0;
                end
            end
        end

        assign req[g]   = !cfg_mask[g] && (cfg_level[g] ? (cond && !svc_q) : pend_q);
        assign insvc[g] = svc_q;
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NUM_IN = 24,
    localparam int IW = $clog2(NUM_IN)
) (
    input  logic [NUM_IN-1:0] req,
    output logic              gnt_valid,
    output logic [IW-1:0]     gnt_idx
);
    always_comb begin
        gnt_valid = |req;
        gnt_idx   = '0;
        for (int i = NUM_IN - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt_idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int         NUM_IN  = 24,
    parameter logic [7:0] VERSION = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_IN-1:0] irq_in,
    input  logic              eoi_valid,
    input  logic [7:0]        eoi_vector,
    output logic              dlv_req,
    output logic [7:0]        dlv_vector,
    output logic [7:0]        dlv_dest,
    output logic              dlv_logical,
    input  logic              dlv_ack
);
    localparam int IW = $clog2(NUM_IN);

    logic [NUM_IN-1:0]      cfg_mask, cfg_level, cfg_actlow, cfg_logical;
    logic [NUM_IN-1:0][7:0] cfg_vec, cfg_dest;
    logic [NUM_IN-1:0]      req, insvc, ack_hot;
    logic                   gnt_valid;
    logic [IW-1:0]          gnt_idx, held_idx_q;
    dlv_state_e             state_q, state_d;

    irq_regfile #(.NUM_IN(NUM_IN), .VERSION(VERSION)) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .insvc(insvc), .cfg_mask(cfg_mask), .cfg_level(cfg_level),
        .cfg_actlow(cfg_actlow), .cfg_logical(cfg_logical),
        .cfg_vec(cfg_vec), .cfg_dest(cfg_dest)
    );

    irq_detect #(.NUM_IN(NUM_IN)) det_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_mask(cfg_mask),
        .cfg_level(cfg_level), .cfg_actlow(cfg_actlow), .cfg_vec(cfg_vec),
        .ack_hot(ack_hot), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .req(req), .insvc(insvc)
    );

    irq_arbiter #(.NUM_IN(NUM_IN)) arb_i (
        .req(req), .gnt_valid(gnt_valid), .gnt_idx(gnt_idx)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (gnt_valid) state_d = ST_OFFER;
            ST_OFFER: if (dlv_ack)   state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // captured delivery fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_idx_q  <= '0;
            dlv_vector  <= '0;
            dlv_dest    <= '0;
            dlv_logical <= 1'b0;
        end else if (state_q == ST_IDLE && gnt_valid) begin
            held_idx_q  <= gnt_idx;
            dlv_vector  <= cfg_vec[gnt_idx];
            dlv_dest    <= cfg_dest[gnt_idx];
            dlv_logical <= cfg_logical[gnt_idx];
        end
    end

    assign dlv_req = (state_q == ST_OFFER);

    always_comb begin
        ack_hot = '0;
        if (state_q == ST_OFFER && dlv_ack) begin
            ack_hot[held_idx_q] = 1'b1;
        end
    end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int         NUM_IN  = 24,
    parameter logic [7:0] VERSION = 8'h20
) (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  bus_addr,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        dlv_req,
    input logic [7:0]  dlv_vector,
    input logic [7:0]  dlv_dest,
    input logic        dlv_logical,
    input logic        dlv_ack
);
    logic [7:0] shadow_idx;
    logic       win_rd;

    always_ff @(posedge clk) begin
        if (!rst_n)                         shadow_idx <= '0;
        else if (bus_wr && bus_addr == 8'h00) shadow_idx <= bus_wdata[7:0];
    end

    assign win_rd = bus_rd && (bus_addr == 8'h10);

    // R11
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_req && !dlv_ack |=> dlv_req && $stable(dlv_vector)
                                && $stable(dlv_dest) && $stable(dlv_logical));

    // R11
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_req && dlv_ack |=> !dlv_req);

    // R3
    version_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_rd && shadow_idx == 8'h01 |->
            bus_rdata == {8'h00, 8'(NUM_IN - 1), 8'h00, VERSION});

    // R2
    id_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_rd && shadow_idx == 8'h00 |-> bus_rdata[23:0] == 24'h0
                                          && bus_rdata[31:28] == 4'h0);

    // R6
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_rd && ((shadow_idx >= 8'h02 && shadow_idx < 8'h10)
                   || shadow_idx >= 8'(16 + 2*NUM_IN)) |-> bus_rdata == 32'h0);

    // R1
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == 32'h0);
endmodule

bind irq_router irq_router_chk #(.NUM_IN(NUM_IN), .VERSION(VERSION)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dlv_req(dlv_req), .dlv_vector(dlv_vector), .dlv_dest(dlv_dest),
    .dlv_logical(dlv_logical), .dlv_ack(dlv_ack)
);

// File: tb/irq_router_tb_top.sv
module irq_router_tb_top;
    localparam int N = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] irq_in = '0;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = '0;
    logic        dlv_req, dlv_logical, dlv_ack = 1'b0;
    logic [7:0]  dlv_vector, dlv_dest;

    int checks = 0, fails = 0;
    logic [31:0] mdl [0:255];

    always #2 clk = ~clk;

    irq_router #(.NUM_IN(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .dlv_req(dlv_req), .dlv_vector(dlv_vector), .dlv_dest(dlv_dest),
        .dlv_logical(dlv_logical), .dlv_ack(dlv_ack)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] lo_idx(input int n); return 8'(16 + 2*n); endfunction

    function automatic logic [31:0] exp_rd(input logic [7:0] idx);
        if (idx == 8'h00) return mdl[0] & 32'h0F00_0000;
        if (idx == 8'h01) return 32'h0017_0020;
        if (idx >= 8'h10 && idx < 8'(16 + 2*N))
            return idx[0] ? (mdl[idx] & 32'hFF00_0000) : (mdl[idx] & 32'h0001_A8FF);
        return 32'h0;
    endfunction

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 256; i++) mdl[i] = 32'h0;
        for (int i = 0; i < N; i++) mdl[lo_idx(i)] = 32'h0001_0000;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [31:0] d);
        bus_write(8'h00, {24'h0, idx});
        bus_write(8'h10, d);
        mdl[idx] = d;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] idx, output logic [31:0] d);
        bus_write(8'h00, {24'h0, idx});
        bus_read(8'h10, d);
    endtask

    task automatic wait_req(input int lim, output logic got);
        got = 1'b0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (dlv_req) begin got = 1'b1; break; end
        end
    endtask

    task automatic do_ack();
        @(negedge clk); dlv_ack = 1'b1;
        @(negedge clk); dlv_ack = 1'b0;
        check("R11 req low after ack", {31'h0, dlv_req}, 32'h0);
    endtask

    task automatic quiet(input string tag, input int cyc);
        logic seen = 1'b0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (dlv_req) seen = 1'b1;
        end
        check(tag, {31'h0, seen}, 32'h0);
    endtask

    task automatic pulse_eoi(input logic [7:0] v);
        @(negedge clk); eoi_valid = 1'b1; eoi_vector = v;
        @(negedge clk); eoi_valid = 1'b0;
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d, v0, d0;
        logic got;
        void'($urandom(32'd4242));
        do_reset();

        // R5 reset state
        @(negedge clk);
        check("R5 no request after reset", {31'h0, dlv_req}, 32'h0);
        reg_read(lo_idx(0), d);      check("R5 entry0 low", d, 32'h0001_0000);
        reg_read(lo_idx(N-1), d);    check("R5 entry23 low", d, 32'h0001_0000);
        reg_read(lo_idx(N-1) + 1, d); check("R5 entry23 high", d, 32'h0);

        // R3 version, read-only
        reg_read(8'h01, d);          check("R3 version", d, 32'h0017_0020);
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_read(8'h10, d);          check("R3 write ignored", d, 32'h0017_0020);

        // R2 ID, R1 index readback and stray offset
        reg_write(8'h00, 32'hFFFF_FFFF);
        bus_read(8'h10, d);          check("R2 id field", d, 32'h0F00_0000);
        bus_read(8'h00, d);          check("R1 index readback", d, 32'h0);
        bus_write(8'h00, 32'h0000_0025);
        bus_read(8'h00, d);          check("R1 index readback 0x25", d, 32'h25);
        bus_read(8'h08, d);          check("R1 stray offset", d, 32'h0);

        // R6 unimplemented
        bus_write(8'h00, 32'h05); bus_write(8'h10, 32'hFFFF_FFFF);
        bus_read(8'h10, d);          check("R6 index 0x05", d, 32'h0);
        bus_write(8'h00, 32'h40); bus_write(8'h10, 32'hFFFF_FFFF);
        bus_read(8'h10, d);          check("R6 index 0x40", d, 32'h0);

        // R4 / R13 random register traffic against model
        for (int k = 0; k < 300; k++) begin
            logic [7:0] ix = 8'($urandom_range(0, 8'h45));
            logic [31:0] dv = $urandom();
            if (ix == 8'h01) continue;
            reg_write(ix, dv);
        end
        for (int ix = 0; ix < 8'h46; ix++) begin
            reg_read(8'(ix), d);
            check($sformatf("R4 R13 readback idx %0h", ix), d, exp_rd(8'(ix)));
        end

        do_reset();

        // R7 edge delivery, R11 hold
        reg_write(lo_idx(3), 32'h0000_0841);
        reg_write(lo_idx(3) + 1, 32'h5A00_0000);
        @(negedge clk); irq_in[3] = 1'b1;
        @(negedge clk); irq_in[3] = 1'b0;
        wait_req(8, got);
        check("R7 edge request", {31'h0, got}, 32'h1);
        check("R7 vector", {24'h0, dlv_vector}, 32'h41);
        check("R7 dest", {24'h0, dlv_dest}, 32'h5A);
        check("R7 logical", {31'h0, dlv_logical}, 32'h1);
        v0 = {24'h0, dlv_vector}; d0 = {24'h0, dlv_dest};
        reg_write(lo_idx(3), 32'h0000_0099);
        check("R11 vector held", {24'h0, dlv_vector}, v0);
        check("R11 dest held", {24'h0, dlv_dest}, d0);
        check("R11 req held", {31'h0, dlv_req}, 32'h1);
        do_ack();
        quiet("R7 single delivery per edge", 6);

        // R8 active-low
        reg_write(lo_idx(5), 32'h0001_A055);
        @(negedge clk); irq_in[5] = 1'b1;
        repeat (2) @(negedge clk);
        reg_write(lo_idx(5), 32'h0000_2055);
        quiet("R8 idle high gives nothing", 4);
        @(negedge clk); irq_in[5] = 1'b0;
        wait_req(8, got);
        check("R8 falling edge delivers", {31'h0, got}, 32'h1);
        check("R8 vector", {24'h0, dlv_vector}, 32'h55);
        do_ack();
        @(negedge clk); irq_in[5] = 1'b1;

        // R9 level and in-service
        reg_write(lo_idx(7), 32'h0000_8077);
        @(negedge clk); irq_in[7] = 1'b1;
        wait_req(8, got);
        check("R9 level request", {31'h0, got}, 32'h1);
        check("R9 vector", {24'h0, dlv_vector}, 32'h77);
        do_ack();
        reg_read(lo_idx(7), d);
        check("R9 in-service bit", d, 32'h0000_C077);
        quiet("R9 no repeat while in service", 5);
        pulse_eoi(8'h99);
        quiet("R9 other vector keeps in service", 4);
        pulse_eoi(8'h77);
        wait_req(8, got);
        check("R9 re-request after eoi", {31'h0, got}, 32'h1);
        do_ack();
        @(negedge clk); irq_in[7] = 1'b0;
        pulse_eoi(8'h77);
        reg_read(lo_idx(7), d);
        check("R9 in-service cleared", d, 32'h0000_8077);

        // R10 priority
        reg_write(lo_idx(10), 32'h0000_00A0);
        reg_write(lo_idx(2), 32'h0000_0020);
        @(negedge clk); irq_in[10] = 1'b1; irq_in[2] = 1'b1;
        @(negedge clk); irq_in[10] = 1'b0; irq_in[2] = 1'b0;
        wait_req(8, got);
        check("R10 lowest first", {24'h0, dlv_vector}, 32'h20);
        do_ack();
        wait_req(8, got);
        check("R10 then higher", {24'h0, dlv_vector}, 32'hA0);
        do_ack();

        // R12 masked edge stays latched
        reg_write(lo_idx(12), 32'h0001_00C0);
        @(negedge clk); irq_in[12] = 1'b1;
        @(negedge clk); irq_in[12] = 1'b0;
        quiet("R12 masked no delivery", 6);
        reg_write(lo_idx(12), 32'h0000_00C0);
        wait_req(8, got);
        check("R12 delivered on unmask", {31'h0, got}, 32'h1);
        check("R12 vector", {24'h0, dlv_vector}, 32'hC0);
        do_ack();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule